// File: doc/BRIEF.md
# I2C Master Byte Transmitter

This block is the transmit half of an I2C master that a processor drives through a small register interface. Software asks for a start condition. It then writes bytes one at a time, and the block shifts each byte onto the bus as a nine-clock frame. The first byte after a start holds the 7-bit slave address and the direction bit. Writing that byte in the right form is left to software. Between frames the block parks SCL low, so a slow program never breaks the bus timing. A stop condition is issued on request.

There are two byte stores. The data register takes the write from software. A shift register holds the byte that is on the wire. Because of this, the next byte can be queued while the current frame is still being sent. A frame-done flag rises on the ninth SCL rising edge and can raise an interrupt. The next frame starts only after software has cleared that flag and a byte has moved into the shift register. Both bus lines are open-drain: the block outputs a pull-low enable for each line and reads the line level back.

The register interface has two addresses, selected by `wr_addr`:
- Address 0 is control.
  - bit0 = go
  - bit1 = stop-control
  - bit2 = flag keep (0 clears the frame-done flag)
  - bit3 = interrupt enable
  - bits6:4 = rate select
- Address 1 is transmit data.

Top module: `i2c_tx_master`

## Requirements
- R1: After reset, both pull-low enables are 0, busy is 0, the empty flag is 1, and the frame-done flag, the ready flag, nack and irq are 0.
- R2: A control write with go=1 and stop-control=0 starts a start condition only when the block is idle and both lines read high. In the start condition SDA falls while SCL is high, and busy goes to 1. When the bus is not free, the write has no effect.
- R3: At the end of the start condition, the empty flag, the frame-done flag and the ready flag are all 1. The output irq equals frame-done AND interrupt-enable.
- R4: A write to address 1 makes the empty flag 0 on the next cycle. While SCL is parked and the shift register is vacant, the byte moves into the shift register and the empty flag returns to 1. A byte written during a frame waits in the data register until that frame has ended.
- R5: Each frame sends its 8 data bits MSB first and then releases SDA for a ninth clock. SDA changes only while SCL is low.
- R6: The frame-done flag is set in the same cycle as the ninth SCL rising edge of every frame. A control write with bit2=0 clears the flag. If the clear and the set fall in the same cycle, the set wins.
- R7: Once the start condition or a frame has ended, SCL stays low until a byte is in the shift register and the frame-done flag is 0.
- R8: nack takes the SDA level in the middle of the high phase of the ninth clock: 0 means the slave acknowledged, 1 means no acknowledge.
- R9: A control write with go=0 and stop-control=0 while SCL is parked makes a stop condition. In the stop condition SDA rises while SCL is high, busy returns to 0, and both lines are released.
- R10: With rate select s, every SCL phase lasts (2<<s) clocks per quarter-bit, so the high time and the low time of a data clock are each 2*(2<<s) clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = control, 1 = transmit data |
| wdata | input | 8 | Write data |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| busy | output | 1 | Bus owned between start and stop |
| tx_empty | output | 1 | Data register may be written |
| irq_flag | output | 1 | Frame-done / start-done flag |
| xfer_rdy | output | 1 | Shift register loaded, awaiting frame |
| nack | output | 1 | Last acknowledge bit sampled (1 = none) |
| irq | output | 1 | Interrupt request |

## Verification
The frame-done flag can be set by the ninth SCL rise in the same cycle that software writes a clear to it. The bench provokes this by timing a clear write to land exactly 2*(2<<s) clocks after the eighth counted SCL fall. It then judges that the flag still reads 1 and that SCL stays parked low well past the end of the frame. A second overlap is a data write while the previous byte is still on the wire. In that case the empty flag must stay 0 until the frame ends, and then return to 1.

// File: rtl/i2c_tx_master.sv
module i2c_tx_master #(
  parameter int SEL_W = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       wr_addr,
  input  logic [7:0] wdata,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       scl_oe,
  output logic       sda_oe,
  output logic       busy,
  output logic       tx_empty,
  output logic       irq_flag,
  output logic       xfer_rdy,
  output logic       nack,
  output logic       irq
);
  localparam int CNT_W = (1 << SEL_W) + 1;

  typedef enum logic [2:0] {IDLE, STRT, XFER, HOLD, STOP} st_t;

  st_t              st;
  logic [1:0]       ph;
  logic [3:0]       bitn;
  logic [CNT_W-1:0] cnt;
  logic [SEL_W-1:0] sel;
  logic             ie, sh_full;
  logic [7:0]       tdr, shr;

  wire [CNT_W-1:0] reload = (CNT_W'(2) << sel) - CNT_W'(1);
  wire tick      = (cnt == '0);
  wire ctl_wr    = wr_en && !wr_addr;
  wire dat_wr    = wr_en && wr_addr;
  wire bus_free  = !busy && scl_in && sda_in;
  wire start_req = ctl_wr && (wdata[1:0] == 2'b01) && (st == IDLE) && bus_free;
  wire stop_req  = ctl_wr && (wdata[1:0] == 2'b00) && (st == HOLD);

  assign irq = irq_flag && ie;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; ph <= '0; bitn <= '0; cnt <= '0; sel <= '0; ie <= 1'b0;
      sh_full <= 1'b0; tdr <= '0; shr <= '0; scl_oe <= 1'b0; sda_oe <= 1'b0;
      busy <= 1'b0; tx_empty <= 1'b1; irq_flag <= 1'b0; xfer_rdy <= 1'b0;
      nack <= 1'b0;
    end else begin
      cnt <= (tick || st == IDLE) ? reload : cnt - CNT_W'(1);
      if (ctl_wr) begin
        ie  <= wdata[3];
        sel <= wdata[4 +: SEL_W];
        if (!wdata[2]) irq_flag <= 1'b0;
      end
      case (st)
        IDLE: if (start_req) begin
          st <= STRT; ph <= '0; busy <= 1'b1;
        end
        STRT: if (tick) begin
          case (ph)
            2'd0: begin sda_oe <= 1'b1; ph <= 2'd1; end
            2'd1: begin scl_oe <= 1'b1; ph <= 2'd2; end
            default: begin
              st <= HOLD; tx_empty <= 1'b1; irq_flag <= 1'b1; xfer_rdy <= 1'b1;
            end
          endcase
        end
        HOLD: begin
          if (!tx_empty && !sh_full) begin
            shr <= tdr; sh_full <= 1'b1; tx_empty <= 1'b1; xfer_rdy <= 1'b1;
          end
          if (stop_req) begin
            st <= STOP; ph <= '0; sda_oe <= 1'b1; sh_full <= 1'b0;
          end else if (sh_full && !irq_flag && tick) begin
            st <= XFER; ph <= '0; bitn <= '0; sda_oe <= ~shr[7];
            sh_full <= 1'b0; xfer_rdy <= 1'b0;
          end
        end
        XFER: if (tick) begin
          case (ph)
            2'd0: ph <= 2'd1;
            2'd1: begin
              scl_oe <= 1'b0; ph <= 2'd2;
              if (bitn == 4'd8) irq_flag <= 1'b1;
            end
            2'd2: begin
              if (bitn == 4'd8) nack <= sda_in;
              ph <= 2'd3;
            end
            default: begin
              scl_oe <= 1'b1; ph <= 2'd0;
              if (bitn == 4'd8) st <= HOLD;
              else begin
                bitn   <= bitn + 4'd1;
                shr    <= {shr[6:0], 1'b0};
                sda_oe <= (bitn == 4'd7) ? 1'b0 : ~shr[6];
              end
            end
          endcase
        end
        STOP: if (tick) begin
          if (ph == 2'd0) begin scl_oe <= 1'b0; ph <= 2'd1; end
          else begin sda_oe <= 1'b0; st <= IDLE; busy <= 1'b0; end
        end
        default: st <= IDLE;
      endcase
      if (dat_wr) begin
        tdr <= wdata; tx_empty <= 1'b0;
      end
    end
  end

  // R5
  sda_while_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == XFER && !scl_oe) |=> (scl_oe || $stable(sda_oe)));

  // R7
  hold_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == HOLD) |-> scl_oe);

  // R2
  start_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(scl_in && sda_in));

  // R6
  irq_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_flag) |-> (st == HOLD || (st == XFER && bitn == 4'd8 && !scl_oe)));

  // R4
  empty_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr) |=> !tx_empty);

  // R9
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (!scl_oe && !sda_oe));
endmodule

// File: tb/tb_i2c_tx_master.sv
module tb_i2c_tx_master;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, wr_addr = 1'b0;
  logic [7:0] wdata = '0;
  logic scl_oe, sda_oe, busy, tx_empty, irq_flag, xfer_rdy, nack, irq;
  logic ext_scl = 1'b0, slave_pull = 1'b0;
  wire scl = !scl_oe && !ext_scl;
  wire sda = !sda_oe && !slave_pull;

  always #4 clk = ~clk;

  i2c_tx_master dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wdata(wdata),
    .scl_in(scl), .sda_in(sda), .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy),
    .tx_empty(tx_empty), .irq_flag(irq_flag), .xfer_rdy(xfer_rdy), .nack(nack), .irq(irq));

  int errors = 0, checks = 0, qv = 4;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // bus monitor and slave model, evaluated every clock
  byte unsigned exp_byte[$];
  bit           exp_ack[$];
  logic p_scl = 1'b1, p_sda = 1'b1, p_irq = 1'b0;
  bit active = 0, skip = 0, fresh = 0;
  int falls = 0, hcnt = 0, starts = 0, stops = 0, frames = 0;
  logic [8:0] got = '0;
  logic rise_bit = 1'b0;

  always @(negedge clk) if (rst_n && !done) begin
    if (sda != p_sda && scl && p_scl) begin
      if (!sda) begin starts++; active = 1; skip = 1; fresh = 1; falls = 0; end
      else begin stops++; active = 0; end
    end
    if (scl && !p_scl) begin hcnt = 1; rise_bit = sda; if (active && !skip) fresh = 0; end
    else if (scl) hcnt++;
    if (irq_flag && !p_irq) begin
      chk((active && scl && !p_scl && falls == 8) || (active && fresh && !scl),
          "R6 irq rise timing", falls, 8);
    end
    if (!scl && p_scl && active) begin
      if (skip) skip = 0;
      else begin
        chk(hcnt == 2*qv, "R10 SCL high time", hcnt, 2*qv);
        got = {got[7:0], rise_bit};
        falls++;
        if (falls == 8) slave_pull = (exp_ack.size() > 0) ? exp_ack[0] : 1'b0;
        if (falls == 9) begin
          slave_pull = 1'b0;
          if (exp_byte.size() == 0) chk(0, "R5 unexpected frame", got[8:1], 0);
          else begin
            chk(got[8:1] == exp_byte[0], "R5 byte MSB first", got[8:1], exp_byte[0]);
            chk(got[0] == !exp_ack[0], "R8 ack on bus", got[0], !exp_ack[0]);
            void'(exp_byte.pop_front()); void'(exp_ack.pop_front());
          end
          frames++; falls = 0;
        end
      end
    end
    p_scl = scl; p_sda = sda; p_irq = irq_flag;
  end

  task automatic wr(input bit a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic put(input logic [7:0] b, input bit ack);
    exp_byte.push_back(b); exp_ack.push_back(ack);
    wr(1'b1, b);
  endtask

  task automatic wait_irq_hold();
    int n = 0;
    while (!(irq_flag && scl_oe) && n < 5000) begin @(negedge clk); n++; end
    while (!tx_empty && n < 5000) begin @(negedge clk); n++; end
    repeat (2*qv + 4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!scl_oe && !sda_oe && !busy, "R1 lines released idle", {scl_oe, sda_oe, busy}, 0);
    chk(tx_empty && !irq_flag && !xfer_rdy && !nack && !irq, "R1 flags",
        {tx_empty, irq_flag, xfer_rdy, nack, irq}, 16);

    // start refused while SCL held low externally
    ext_scl = 1'b1;
    wr(1'b0, 8'h1D);
    repeat (20) @(negedge clk);
    chk(!busy && !sda_oe && !scl_oe && starts == 0, "R2 start ignored when bus not free",
        busy, 0);
    ext_scl = 1'b0;
    repeat (4) @(negedge clk);

    wr(1'b0, 8'h1D);
    repeat (40) @(negedge clk);
    chk(starts == 1 && busy, "R2 start condition", starts, 1);
    chk(tx_empty && irq_flag && xfer_rdy, "R3 flags after start",
        {tx_empty, irq_flag, xfer_rdy}, 7);
    chk(irq == 1'b1, "R3 irq output", irq, 1);
    wr(1'b0, 8'h16);
    chk(irq == 1'b0 && irq_flag, "R3 irq masked", irq, 0);
    wr(1'b0, 8'h1E);

    put(8'hA4, 1'b1);
    chk(tx_empty == 1'b0, "R4 write clears empty", tx_empty, 0);
    @(negedge clk);
    chk(tx_empty == 1'b1 && xfer_rdy, "R4 load sets empty", tx_empty, 1);
    repeat (40) @(negedge clk);
    chk(scl_oe == 1'b1 && frames == 0, "R7 SCL parked while flag set", scl_oe, 1);

    wr(1'b0, 8'h1A);
    put(8'h3C, 1'b1);
    repeat (10) @(negedge clk);
    chk(tx_empty == 1'b0, "R4 queued byte waits during frame", tx_empty, 0);
    wait_irq_hold();
    chk(frames == 1 && nack == 1'b0, "R8 ack sampled", nack, 0);
    chk(tx_empty == 1'b1, "R4 queued byte loaded after frame", tx_empty, 1);

    // clear coinciding with the ninth rise
    wr(1'b0, 8'h1A);
    do @(posedge clk); while (falls != 8);
    repeat (2*qv - 2) @(posedge clk);
    @(negedge clk); wr_en = 1'b1; wr_addr = 1'b0; wdata = 8'h1A;
    @(negedge clk); wr_en = 1'b0;
    chk(irq_flag == 1'b1, "R6 set wins over clear", irq_flag, 1);
    repeat (60) @(negedge clk);
    chk(scl_oe == 1'b1 && frames == 2, "R7 parked after frame", frames, 2);

    // slower rate, no acknowledge
    wr(1'b0, 8'h2E);
    qv = 8;
    put(8'h5B, 1'b0);
    wr(1'b0, 8'h2A);
    wait_irq_hold();
    chk(frames == 3 && nack == 1'b1, "R8 nack recorded", nack, 1);

    wr(1'b0, 8'h2C);
    repeat (40) @(negedge clk);
    chk(stops == 1 && !busy, "R9 stop condition", stops, 1);
    chk(!scl_oe && !sda_oe, "R9 lines released", {scl_oe, sda_oe}, 0);
    chk(exp_byte.size() == 0, "R5 all bytes sent", exp_byte.size(), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule